// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block caches address translations for a 32-bit memory management unit. It holds a parameterised number of entries. Each entry stores a virtual tag, a physical base, a permission field, a 4-bit domain and a 3-bit page-size kind. The kind of an entry sets how many upper address bits that entry compares. One table can therefore hold 1 MB regions, 64 KB pages, 4 KB pages and 1 KB pages side by side.

A lookup is purely combinational. It returns a hit flag, the index of the winning entry and that entry's stored fields in the same cycle. Three update commands are sampled on the rising clock edge:
- a fill, which writes the slot chosen by a round-robin pointer;
- a flush, which invalidates every entry and rewinds the pointer;
- a targeted invalidate, which removes the entry that a lookup of a given address would return.

The table walk, the permission checks and the construction of the final physical address are done outside this block.

Top module: `mpsz_tlb`

## Requirements
- R1: After a synchronous reset every entry is invalid, no lookup hits, and the first fill lands in slot 0.
- R2: The kind field is coded 0 = invalid, 1 = 4 KB page, 2 = 64 KB page, 3 = 1 MB region, 4 = extended 4 KB page, 5 = 1 KB page. The compare masks are, in that order, 0x00000000, 0xFFFFF000, 0xFFFF0000, 0xFFF00000, 0xFFFFF000 and 0xFFFFFC00. Codes 6 and 7 behave as invalid.
- R3: A lookup hits on an entry when the lookup address ANDed with that entry's mask equals the entry's stored tag. The hit, the index and the fields (tag, physical base, permissions, domain, kind) appear combinationally in the same cycle.
- R4: An entry whose kind is invalid (0, 6 or 7) never matches, even when it was written by a fill.
- R5: When several entries match, the entry with the lowest index is returned.
- R6: A fill stores its virtual and physical addresses ANDed with the mask of its own kind. Permissions and domain are stored unchanged.
- R7: Each accepted fill writes the slot named by the replacement pointer. The pointer then advances by one and wraps from ENTRIES-1 to 0.
- R8: A flush invalidates all entries and sets the replacement pointer to 0.
- R9: A targeted invalidate clears only the lowest-index entry that matches its address. When nothing matches, no entry changes. The replacement pointer is never moved by it.
- R10: Commands sampled in the same cycle follow a priority. Flush beats targeted invalidate, and targeted invalidate beats fill. A command that loses is ignored entirely; a fill is ignored whenever the invalidate request is high.
- R11: On a miss, the index and all field outputs read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_idx | output | IW | Index of the matching entry |
| lk_vtag | output | 32 | Stored (masked) virtual tag |
| lk_pbase | output | 32 | Stored (masked) physical base |
| lk_perm | output | PERM_W | Stored permission field |
| lk_dom | output | DOM_W | Stored domain |
| lk_kind | output | 3 | Stored page-size kind |
| fl_en | input | 1 | Fill request |
| fl_vaddr | input | 32 | Fill virtual address |
| fl_paddr | input | 32 | Fill physical address |
| fl_perm | input | PERM_W | Fill permission field |
| fl_dom | input | DOM_W | Fill domain |
| fl_kind | input | 3 | Fill page-size kind |
| inv_all | input | 1 | Flush the whole table |
| inv_addr_en | input | 1 | Targeted invalidate request |
| inv_vaddr | input | 32 | Targeted invalidate address |

## Verification
The hardest case to reach is an overlap: a large region and a smaller page that both cover one address, held in slots where the lower index is not the most recent fill. A targeted invalidate must then remove only the lower slot and leave the other one to be found. The stimulus builds this on purpose: a 1 MB region is filled first, then a 4 KB page inside it, the pointer is wrapped past ENTRIES, and the overlapped address is invalidated and looked up again. A long random phase follows. It draws addresses from a few clustered 1 MB windows so that overlaps, kinds 6 and 7, and same-cycle command collisions all occur often.

// File: rtl/mpsz_tlb_pkg.sv
package mpsz_tlb_pkg;

  localparam int ADDR_W = 32;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    PK_NONE   = 3'd0,
    PK_SMALL  = 3'd1,
    PK_LARGE  = 3'd2,
    PK_SECT   = 3'd3,
    PK_XSMALL = 3'd4,
    PK_TINY   = 3'd5
  } pg_kind_e;

  // Compare mask selected by the page-size kind; unknown codes compare nothing.
  function automatic logic [ADDR_W-1:0] kind_mask(input logic [KIND_W-1:0] k);
    case (k)
      PK_SMALL:  kind_mask = 32'hFFFF_F000;
      PK_LARGE:  kind_mask = 32'hFFFF_0000;
      PK_SECT:   kind_mask = 32'hFFF0_0000;
      PK_XSMALL: kind_mask = 32'hFFFF_F000;
      PK_TINY:   kind_mask = 32'hFFFF_FC00;
      default:   kind_mask = 32'h0000_0000;
    endcase
  endfunction

  function automatic logic kind_live(input logic [KIND_W-1:0] k);
    kind_live = (k >= 3'd1) && (k <= 3'd5);
  endfunction

endpackage

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank
  import mpsz_tlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int PW     = 12,
  parameter int DW     = 4,
  parameter int IW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [ADDR_W-1:0] wr_tag,
  input  logic [ADDR_W-1:0] wr_pbase,
  input  logic [PW-1:0]     wr_perm,
  input  logic [DW-1:0]     wr_dom,
  input  logic [KIND_W-1:0] wr_kind,
  input  logic              kill_all,
  input  logic              kill_en,
  input  logic [IW-1:0]     kill_idx,
  output logic [ADDR_W-1:0] tag_q   [N],
  output logic [ADDR_W-1:0] pbase_q [N],
  output logic [PW-1:0]     perm_q  [N],
  output logic [DW-1:0]     dom_q   [N],
  output logic [KIND_W-1:0] kind_q  [N]
);

  // Payload storage: no reset, written only by fills.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]   <= wr_tag;
      pbase_q[wr_idx] <= wr_pbase;
      perm_q[wr_idx]  <= wr_perm;
      dom_q[wr_idx]   <= wr_dom;
    end
  end

  // Kind field per slot: reset, flush and targeted kill.
  for (genvar g = 0; g < N; g++) begin : g_kind
    always_ff @(posedge clk) begin
      if (rst || kill_all) begin
        kind_q[g] <= PK_NONE;
      end else if (kill_en && (kill_idx == IW'(g))) begin
        kind_q[g] <= PK_NONE;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        kind_q[g] <= wr_kind;
      end
    end
  end

endmodule

// File: rtl/tlb_match_vec.sv
module tlb_match_vec
  import mpsz_tlb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [ADDR_W-1:0] probe,
  input  logic [ADDR_W-1:0] tag_q  [N],
  input  logic [KIND_W-1:0] kind_q [N],
  output logic [N-1:0]      hit_v
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    always_comb begin
      hit_v[g] = kind_live(kind_q[g]) &&
                 ((probe & kind_mask(kind_q[g])) == tag_q[g]);
    end
  end

endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] ptr_q
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/mpsz_tlb.sv
module mpsz_tlb
  import mpsz_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PERM_W  = 12,
  parameter int DOM_W   = 4,
  parameter int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       lk_vaddr,
  output logic              lk_hit,
  output logic [IW-1:0]     lk_idx,
  output logic [31:0]       lk_vtag,
  output logic [31:0]       lk_pbase,
  output logic [PERM_W-1:0] lk_perm,
  output logic [DOM_W-1:0]  lk_dom,
  output logic [2:0]        lk_kind,
  input  logic              fl_en,
  input  logic [31:0]       fl_vaddr,
  input  logic [31:0]       fl_paddr,
  input  logic [PERM_W-1:0] fl_perm,
  input  logic [DOM_W-1:0]  fl_dom,
  input  logic [2:0]        fl_kind,
  input  logic              inv_all,
  input  logic              inv_addr_en,
  input  logic [31:0]       inv_vaddr
);

  logic [ADDR_W-1:0] tag_q   [ENTRIES];
  logic [ADDR_W-1:0] pbase_q [ENTRIES];
  logic [PERM_W-1:0] perm_q  [ENTRIES];
  logic [DOM_W-1:0]  dom_q   [ENTRIES];
  logic [KIND_W-1:0] kind_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_vec, iv_vec;
  logic               lk_found, iv_found;
  logic [IW-1:0]      lk_sel, iv_sel;
  logic [IW-1:0]      ptr_q;

  // Command priority: flush, then targeted invalidate, then fill.
  logic do_kill, do_fill;
  logic [ADDR_W-1:0] fl_mask;

  always_comb begin
    do_kill = !inv_all && inv_addr_en && iv_found;
    do_fill = !inv_all && !inv_addr_en && fl_en;
    fl_mask = kind_mask(fl_kind);
  end

  tlb_entry_bank #(
    .N(ENTRIES), .PW(PERM_W), .DW(DOM_W), .IW(IW)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (do_fill),
    .wr_idx   (ptr_q),
    .wr_tag   (fl_vaddr & fl_mask),
    .wr_pbase (fl_paddr & fl_mask),
    .wr_perm  (fl_perm),
    .wr_dom   (fl_dom),
    .wr_kind  (fl_kind),
    .kill_all (inv_all),
    .kill_en  (do_kill),
    .kill_idx (iv_sel),
    .tag_q    (tag_q),
    .pbase_q  (pbase_q),
    .perm_q   (perm_q),
    .dom_q    (dom_q),
    .kind_q   (kind_q)
  );

  tlb_match_vec #(.N(ENTRIES)) u_lk_cmp (
    .probe  (lk_vaddr),
    .tag_q  (tag_q),
    .kind_q (kind_q),
    .hit_v  (lk_vec)
  );

  tlb_match_vec #(.N(ENTRIES)) u_iv_cmp (
    .probe  (inv_vaddr),
    .tag_q  (tag_q),
    .kind_q (kind_q),
    .hit_v  (iv_vec)
  );

  tlb_first_set #(.N(ENTRIES), .IW(IW)) u_lk_pick (
    .vec   (lk_vec),
    .found (lk_found),
    .idx   (lk_sel)
  );

  tlb_first_set #(.N(ENTRIES), .IW(IW)) u_iv_pick (
    .vec   (iv_vec),
    .found (iv_found),
    .idx   (iv_sel)
  );

  tlb_rr_ptr #(.N(ENTRIES), .IW(IW)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .clr   (inv_all),
    .adv   (do_fill),
    .ptr_q (ptr_q)
  );

  // Lookup result: fields of the winner, zero on a miss.
  always_comb begin
    lk_hit   = lk_found;
    lk_idx   = '0;
    lk_vtag  = '0;
    lk_pbase = '0;
    lk_perm  = '0;
    lk_dom   = '0;
    lk_kind  = '0;
    if (lk_found) begin
      lk_idx   = lk_sel;
      lk_vtag  = tag_q[lk_sel];
      lk_pbase = pbase_q[lk_sel];
      lk_perm  = perm_q[lk_sel];
      lk_dom   = dom_q[lk_sel];
      lk_kind  = kind_q[lk_sel];
    end
  end

endmodule

// File: rtl/mpsz_tlb_chk.sv
module mpsz_tlb_chk
  import mpsz_tlb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [31:0]   lk_vaddr,
  input logic          lk_hit,
  input logic [IW-1:0] lk_idx,
  input logic [31:0]   lk_vtag,
  input logic [31:0]   lk_pbase,
  input logic [2:0]    lk_kind,
  input logic          fl_en,
  input logic          inv_all,
  input logic          inv_addr_en,
  input logic [IW-1:0] ptr_q
);

  // R3
  hit_tag_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> ((lk_vaddr & kind_mask(lk_kind)) == lk_vtag));

  // R4
  hit_kind_live_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_kind >= 3'd1 && lk_kind <= 3'd5));

  // R6
  pbase_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> ((lk_pbase & ~kind_mask(lk_kind)) == 32'd0));

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (!lk_hit && ptr_q == '0));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fl_en && !inv_all && !inv_addr_en) |=>
      (ptr_q == (($past(ptr_q) == IW'(N - 1)) ? '0 : $past(ptr_q) + 1'b1)));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inv_all && (inv_addr_en || !fl_en)) |=> $stable(ptr_q));

  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_idx == '0 && lk_vtag == 32'd0 && lk_pbase == 32'd0 && lk_kind == 3'd0));

endmodule

bind mpsz_tlb mpsz_tlb_chk #(.N(ENTRIES), .IW(IW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_vaddr    (lk_vaddr),
  .lk_hit      (lk_hit),
  .lk_idx      (lk_idx),
  .lk_vtag     (lk_vtag),
  .lk_pbase    (lk_pbase),
  .lk_kind     (lk_kind),
  .fl_en       (fl_en),
  .inv_all     (inv_all),
  .inv_addr_en (inv_addr_en),
  .ptr_q       (ptr_q)
);

// File: tb/mpsz_tlb_tb.sv
`timescale 1ns/1ps
module mpsz_tlb_tb;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [31:0]   lk_vaddr;
  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  logic [31:0]   lk_vtag, lk_pbase;
  logic [11:0]   lk_perm;
  logic [3:0]    lk_dom;
  logic [2:0]    lk_kind;
  logic          fl_en;
  logic [31:0]   fl_vaddr, fl_paddr;
  logic [11:0]   fl_perm;
  logic [3:0]    fl_dom;
  logic [2:0]    fl_kind;
  logic          inv_all, inv_addr_en;
  logic [31:0]   inv_vaddr;

  always #2 clk = ~clk;

  mpsz_tlb #(.ENTRIES(N), .PERM_W(12), .DOM_W(4)) u_dut (.*);

  // Behavioural reference model
  logic [31:0] m_tag [N];
  logic [31:0] m_pb  [N];
  logic [11:0] m_pm  [N];
  logic [3:0]  m_dm  [N];
  int          m_kd  [N];
  int          m_ptr;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;

  function automatic logic [31:0] msk(int k);
    case (k)
      1: return 32'hFFFFF000;
      2: return 32'hFFFF0000;
      3: return 32'hFFF00000;
      4: return 32'hFFFFF000;
      5: return 32'hFFFFFC00;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int find(logic [31:0] a);
    for (int i = 0; i < N; i++)
      if (m_kd[i] >= 1 && m_kd[i] <= 5 && ((a & msk(m_kd[i])) == m_tag[i])) return i;
    return -1;
  endfunction

  task automatic compare(string rq);
    int w;
    logic [31:0] ev, ep; logic [11:0] epm; logic [3:0] ed; logic [2:0] ek; logic eh; logic [IW-1:0] ei;
    w = find(lk_vaddr);
    eh = (w >= 0); ei = '0; ev = '0; ep = '0; epm = '0; ed = '0; ek = '0;
    if (w >= 0) begin
      ei = IW'(w); ev = m_tag[w]; ep = m_pb[w]; epm = m_pm[w]; ed = m_dm[w]; ek = 3'(m_kd[w]);
    end
    n_chk++;
    if ({lk_hit, lk_idx, lk_vtag, lk_pbase, lk_perm, lk_dom, lk_kind} !==
        {eh, ei, ev, ep, epm, ed, ek}) begin
      n_bad++;
      $display("FAIL %s addr=%h act hit=%0d idx=%0d tag=%h pb=%h pm=%h dm=%h k=%0d exp hit=%0d idx=%0d tag=%h pb=%h pm=%h dm=%h k=%0d",
        rq, lk_vaddr, lk_hit, lk_idx, lk_vtag, lk_pbase, lk_perm, lk_dom, lk_kind,
        eh, ei, ev, ep, epm, ed, ek);
    end
  endtask

  task automatic model_edge();
    int w;
    if (rst || inv_all) begin
      for (int i = 0; i < N; i++) m_kd[i] = 0;
      m_ptr = 0;
    end else if (inv_addr_en) begin
      w = find(inv_vaddr);
      if (w >= 0) m_kd[w] = 0;
    end else if (fl_en) begin
      m_tag[m_ptr] = fl_vaddr & msk(int'(fl_kind));
      m_pb[m_ptr]  = fl_paddr & msk(int'(fl_kind));
      m_pm[m_ptr]  = fl_perm;
      m_dm[m_ptr]  = fl_dom;
      m_kd[m_ptr]  = int'(fl_kind);
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  // One cycle: inputs already driven at the falling edge.
  task automatic cyc(string rq);
    #1;
    if (!rst) compare(rq);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    fl_en = 0; inv_all = 0; inv_addr_en = 0;
  endtask

  task automatic look(logic [31:0] a, string rq);
    lk_vaddr = a; cyc(rq);
  endtask

  task automatic fill(logic [31:0] va, logic [31:0] pa, int k, string rq);
    fl_en = 1; fl_vaddr = va; fl_paddr = pa; fl_kind = 3'(k);
    fl_perm = 12'($urandom); fl_dom = 4'($urandom);
    lk_vaddr = va; cyc(rq);
  endtask

  task automatic kill(logic [31:0] a, string rq);
    inv_addr_en = 1; inv_vaddr = a; lk_vaddr = a; cyc(rq);
  endtask

  task automatic flush(string rq);
    inv_all = 1; cyc(rq);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_kd[i] = 0; m_tag[i] = 0; m_pb[i] = 0; m_pm[i] = 0; m_dm[i] = 0; end
    m_ptr = 0;
    rst = 1; fl_en = 0; inv_all = 0; inv_addr_en = 0;
    lk_vaddr = 0; fl_vaddr = 0; fl_paddr = 0; fl_perm = 0; fl_dom = 0; fl_kind = 0; inv_vaddr = 0;
    @(negedge clk); cyc("R1"); cyc("R1");
    rst = 0;

    // R1: empty table
    look(32'h0000_0000, "R1"); look(32'hFFFF_FFFF, "R1");
    // R1 / R7: first fill goes to slot 0
    fill(32'h1234_5678, 32'hABCD_EF01, 1, "R1 R6");
    look(32'h1234_5FFF, "R3"); look(32'h1234_6000, "R2");
    // R2: each kind's mask boundaries
    fill(32'h2345_6789, 32'h0765_4321, 2, "R6");
    look(32'h2345_0000, "R2"); look(32'h2345_FFFF, "R2"); look(32'h2346_0000, "R2");
    fill(32'h3456_789A, 32'h89AB_CDEF, 3, "R6");
    look(32'h3450_0000, "R2"); look(32'h345F_FFFF, "R2"); look(32'h3460_0000, "R2");
    fill(32'h4567_89AB, 32'h1111_2222, 4, "R6");
    look(32'h4567_8000, "R2"); look(32'h4567_9000, "R2");
    fill(32'h5678_9ABC, 32'h3333_4444, 5, "R6");
    look(32'h5678_9800, "R2"); look(32'h5678_9BFF, "R2"); look(32'h5678_9C00, "R2");
    // R4: kinds 0, 6, 7 never match
    fill(32'h6000_0000, 32'h0, 0, "R4"); look(32'h6000_0000, "R4"); look(32'h0000_0000, "R4");
    fill(32'h7000_0000, 32'h0, 6, "R4"); look(32'h7000_0000, "R4");
    fill(32'h0000_0000, 32'h0, 7, "R4"); look(32'h0000_0000, "R4");
    // R7: wrap to slot 0; R5: overlap region + page
    fill(32'h40000000, 32'hC000_0000, 3, "R7");
    look(32'h4000_1234, "R7");
    fill(32'h40001000, 32'hD000_1000, 1, "R5");
    look(32'h4000_1234, "R5"); look(32'h4000_2000, "R5");
    // R9: targeted invalidate, lowest matching slot only
    kill(32'h4000_1234, "R9");
    look(32'h4000_1234, "R9"); look(32'h4000_2000, "R9");
    kill(32'h9999_9999, "R9");
    look(32'h2345_0000, "R9"); look(32'h3450_0000, "R9"); look(32'h4567_8000, "R9");
    // R10: collisions
    fill(32'hA000_0000, 32'hA000_0000, 3, "R10");
    inv_addr_en = 1; inv_vaddr = 32'hA000_0000; fl_en = 1; fl_vaddr = 32'hB000_0000; fl_kind = 3; lk_vaddr = 32'hB000_0000; cyc("R10");
    look(32'hA000_0000, "R10"); look(32'hB000_0000, "R10");
    inv_all = 1; inv_addr_en = 1; fl_en = 1; fl_vaddr = 32'hC000_0000; fl_kind = 3; cyc("R10");
    look(32'hC000_0000, "R10");
    // R8: flush then first fill lands in slot 0
    fill(32'hE000_0000, 32'h0, 3, "R8"); fill(32'hE010_0000, 32'h0, 3, "R8");
    flush("R8"); look(32'hE000_0000, "R8");
    fill(32'hE010_0000, 32'h5, 3, "R8"); look(32'hE010_0000, "R8 R11");
    look(32'hE020_0000, "R11");

    // Random phase, clustered addresses
    for (int t = 0; t < 20000; t++) begin
      int r;
      logic [31:0] base [4];
      base[0] = 32'h0000_0000; base[1] = 32'h4000_0000; base[2] = 32'h4010_0000; base[3] = 32'h8000_0000;
      r = int'($urandom % 100);
      lk_vaddr = base[$urandom % 4] | ($urandom & 32'h000F_FFFF);
      if (r < 3) inv_all = 1;
      if (r >= 3 && r < 18) begin inv_addr_en = 1; inv_vaddr = base[$urandom % 4] | ($urandom & 32'h000F_FFFF); end
      if (r >= 10 && r < 50) begin
        fl_en = 1; fl_vaddr = base[$urandom % 4] | ($urandom & 32'h000F_FFFF);
        fl_paddr = $urandom; fl_kind = 3'($urandom); fl_perm = 12'($urandom); fl_dom = 4'($urandom);
      end
      cyc("R3 R5 R7 R9 R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule